// File: doc/BRIEF.md
# Three-Wire Radio Register Access Master

This block lets on-chip logic read and write the control registers of a companion radio transceiver over three wires: a serial clock, an active-low frame enable and one serial data line that carries traffic in both directions. A local requester presents a command: a read or write flag, a 7-bit register address and 16 bits of write data. The block serializes the command, clocks it out and, for a read, releases the data line partway through the frame. It then collects the 16-bit reply and reports completion with a one-cycle done pulse. Writes set items such as transmitter, receiver, synthesizer and PLL enables. Reads typically fetch a received signal strength value.

The shared data line appears at the block edge as separate output, output-enable and input signals, which a pad cell joins at chip level. The serial clock runs at the system clock divided by an even build-time divider. Only one frame is in flight at a time. A requester holds its request until the ready signal accepts it.

Top module: `radio_reg_master`

## Requirements
- R1: The frame opens with a direction bit (1 = read, 0 = write), followed by the 7-bit address, MSB first. A write then sends 16 data bits, MSB first. Each bit is placed on the line while the serial clock is low and held unchanged while it is high.
- R2: Each serial clock half-period lasts CLK_DIV/2 system clocks (default 4). The first rising edge comes CLK_DIV/2 system clocks after the enable falls.
- R3: A write frame has exactly 24 serial clock pulses. A read frame has exactly 25.
- R4: In a read, sd_oe is low from the 9th clock (the turnaround clock) until the enable rises. The reply is sampled on the rising edges of clocks 10 to 25, MSB first, and presented on rsp_rdata.
- R5: The enable rises CLK_DIV/2 system clocks after the last falling edge of the serial clock. rsp_done is high for exactly the one cycle in which the enable first reads high.
- R6: Whenever the enable is high, the block drives the data line (sd_oe = 1) at 0 and holds the serial clock at 0.
- R7: req_ready drops when a request is accepted. It returns no earlier than two system clocks after the enable rises, so the enable stays high for at least three cycles between frames. A request held against a low ready is served later and never dropped.
- R8: rsp_rdata keeps the value of the last completed read. A write frame leaves it unchanged.
- R9: After reset the enable is high, the serial clock is low, req_ready is high, rsp_done is low, rsp_rdata is 0, and the line is driven at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until accepted |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 7 | Radio register address |
| req_wdata | input | 16 | Data for a write |
| rsp_done | output | 1 | One-cycle pulse at the end of a frame |
| rsp_rdata | output | 16 | Value from the last read |
| sclk | output | 1 | Serial clock to the radio |
| sen_n | output | 1 | Active-low frame enable |
| sd_o | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_i | input | 1 | Data line input value |

## Verification
The hardest case to reach is the turnaround of a read. The master must release the line, and a radio model must start driving exactly one clock later, in step with falling edges that the design alone produces. The bench therefore contains a radio model that watches the serial clock at the system clock's falling edge and drives reply bits chosen per request from the scoreboard entry. The replies include single-bit values at either end of the word. Back-to-back requests, issued while a frame is still running, exercise the hold-off and the gap between frames.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    parameter int RRM_ADDR_W  = 7;
    parameter int RRM_DATA_W  = 16;
    parameter int RRM_HDR_W   = 1 + RRM_ADDR_W;
    parameter int RRM_FRAME_W = RRM_HDR_W + RRM_DATA_W;

    typedef struct packed {
        logic                  rd;
        logic [RRM_ADDR_W-1:0] addr;
        logic [RRM_DATA_W-1:0] wdata;
    } rrm_cmd_t;

    typedef enum logic [1:0] {
        RRM_IDLE = 2'd0,
        RRM_XFER = 2'd1,
        RRM_GAP  = 2'd2
    } rrm_state_e;

    // Serial image of a command: direction, address, then data, MSB first.
    function automatic logic [RRM_FRAME_W-1:0] rrm_pack(input rrm_cmd_t c);
        return {c.rd, c.addr, c.wdata};
    endfunction

endpackage

// File: rtl/rrm_tick.sv
module rrm_tick #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(HALF + 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == CNT_W'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rrm_shift.sv
module rrm_shift
    import rrm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [RRM_FRAME_W-1:0] frame_in,
    input  logic                   shift_en,
    input  logic                   sample_en,
    input  logic                   capture,
    input  logic                   sd_i,
    output logic                   sd_bit,
    output logic [RRM_DATA_W-1:0]  rdata
);
    logic [RRM_FRAME_W-1:0] tx_sr;
    logic [RRM_DATA_W-1:0]  rx_sr;

    assign sd_bit = tx_sr[RRM_FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
            rx_sr <= '0;
            rdata <= '0;
        end else begin
            if (load) begin
                tx_sr <= frame_in;
            end else if (shift_en) begin
                tx_sr <= {tx_sr[RRM_FRAME_W-2:0], 1'b0};
            end
            if (sample_en) begin
                rx_sr <= {rx_sr[RRM_DATA_W-2:0], sd_i};
            end
            if (capture) begin
                rdata <= rx_sr;
            end
        end
    end
endmodule

// File: rtl/rrm_ctrl.sv
module rrm_ctrl
    import rrm_pkg::*;
#(
    parameter int GAP_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_rd,
    input  logic tick,
    output logic req_ready,
    output logic load,
    output logic run,
    output logic sclk,
    output logic sen_n,
    output logic oe,
    output logic shift_en,
    output logic sample_en,
    output logic capture,
    output logic done
);
    localparam int IDX_W = $clog2(RRM_FRAME_W + 2);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    rrm_state_e       state;
    logic [IDX_W-1:0] bit_idx;
    logic [IDX_W-1:0] last_idx;
    logic [GAP_W-1:0] gap_cnt;
    logic             phase;
    logic             rd_q;
    logic             at_tail;

    // A read carries one extra clock for the line turnaround.
    assign last_idx  = rd_q ? IDX_W'(RRM_FRAME_W + 1) : IDX_W'(RRM_FRAME_W);
    assign at_tail   = (bit_idx == last_idx);

    assign run       = (state == RRM_XFER);
    assign req_ready = (state == RRM_IDLE);
    assign load      = req_ready && req_valid;
    assign sclk      = phase;
    assign sen_n     = !run;
    assign oe        = !(run && rd_q && (bit_idx >= IDX_W'(RRM_HDR_W)));
    assign shift_en  = run && tick && phase;
    assign sample_en = run && tick && !phase && rd_q && !at_tail
                       && (bit_idx > IDX_W'(RRM_HDR_W));
    assign capture   = run && tick && !phase && at_tail && rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RRM_IDLE;
            bit_idx <= '0;
            gap_cnt <= '0;
            phase   <= 1'b0;
            rd_q    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                RRM_IDLE: begin
                    if (req_valid) begin
                        state   <= RRM_XFER;
                        rd_q    <= req_rd;
                        bit_idx <= '0;
                        phase   <= 1'b0;
                    end
                end
                RRM_XFER: begin
                    if (tick) begin
                        if (!phase) begin
                            if (at_tail) begin
                                state   <= RRM_GAP;
                                gap_cnt <= '0;
                                done    <= 1'b1;
                            end else begin
                                phase <= 1'b1;
                            end
                        end else begin
                            phase   <= 1'b0;
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                RRM_GAP: begin
                    if (gap_cnt == GAP_W'(GAP_CYC - 1)) begin
                        state <= RRM_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: state <= RRM_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/radio_reg_master.sv
module radio_reg_master
    import rrm_pkg::*;
#(
    parameter int CLK_DIV = 8,
    parameter int GAP_CYC = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_rd,
    input  logic [RRM_ADDR_W-1:0] req_addr,
    input  logic [RRM_DATA_W-1:0] req_wdata,
    output logic                  rsp_done,
    output logic [RRM_DATA_W-1:0] rsp_rdata,
    output logic                  sclk,
    output logic                  sen_n,
    output logic                  sd_o,
    output logic                  sd_oe,
    input  logic                  sd_i
);
    localparam int HALF = CLK_DIV / 2;

    rrm_cmd_t cmd;
    logic     tick, run, load, shift_en, sample_en, capture;

    assign cmd = '{rd: req_rd, addr: req_addr, wdata: req_wdata};

    rrm_tick #(.HALF(HALF)) i_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    rrm_ctrl #(.GAP_CYC(GAP_CYC)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_rd    (req_rd),
        .tick      (tick),
        .req_ready (req_ready),
        .load      (load),
        .run       (run),
        .sclk      (sclk),
        .sen_n     (sen_n),
        .oe        (sd_oe),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .capture   (capture),
        .done      (rsp_done)
    );

    rrm_shift i_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .frame_in  (rrm_pack(cmd)),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .capture   (capture),
        .sd_i      (sd_i),
        .sd_bit    (sd_o),
        .rdata     (rsp_rdata)
    );
endmodule

// File: rtl/rrm_chk.sv
module rrm_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_done,
    input logic sclk,
    input logic sen_n,
    input logic sd_o,
    input logic sd_oe
);
    // R6
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        sen_n |-> (sd_oe && !sd_o && !sclk));

    // R1
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(sd_o));

    // R7
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    idle_gap_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sen_n && $past(sen_n) && $past(sen_n, 2)));

    // R5
    done_edge_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $rose(sen_n));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
endmodule

bind radio_reg_master rrm_chk i_rrm_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .sclk      (sclk),
    .sen_n     (sen_n),
    .sd_o      (sd_o),
    .sd_oe     (sd_oe)
);

// File: tb/test_radio_reg_master.sv
module test_radio_reg_master;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_rd = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        sclk, sen_n, sd_o, sd_oe;
    logic        radio_drv = 1'b1;
    logic        line;

    assign line = sd_oe ? sd_o : radio_drv;

    always #4 clk = ~clk;

    radio_reg_master i_radio_reg_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sclk(sclk), .sen_n(sen_n),
        .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(line)
    );

    typedef struct {
        bit        rd;
        bit [6:0]  addr;
        bit [15:0] wdata;
        bit [15:0] reply;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0, n_fail = 0, pushed = 0, frames = 0, idle_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Driver: holds the request until accepted, pushes the expectation.
    task automatic issue(input bit rd, input bit [6:0] a, input bit [15:0] d, input bit [15:0] rep);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_rd = rd; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        e.rd = rd; e.addr = a; e.wdata = d; e.reply = rep;
        q.push_back(e);
        pushed++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Radio model and monitor, sampled at the falling system clock edge.
    bit        prev_sclk = 0, prev_sen = 1, frame_rd = 0, bad_t = 0, bad_oe = 0, chk_low = 0;
    int        rise_cnt = 0, half_cnt = 0, idle_cnt = 100;
    bit [31:0] cap = '0;
    bit [15:0] last_reply = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (chk_low) begin
                // R5
                chk(rsp_done == 1'b0, "R5 done one cycle", rsp_done, 0);
                chk_low = 0;
            end
            if (prev_sen && !sen_n) begin
                // R7
                chk(idle_cnt >= 3, "R7 idle gap", idle_cnt, 3);
                rise_cnt = 0; cap = '0; half_cnt = 1; bad_t = 0; bad_oe = 0;
            end else if (!sen_n) begin
                if (sclk != prev_sclk) begin
                    if (half_cnt != HALF) bad_t = 1;
                    half_cnt = 1;
                end else begin
                    half_cnt++;
                end
                if (sclk && !prev_sclk) begin
                    rise_cnt++;
                    cap = {cap[30:0], line};
                    if (rise_cnt == 1) frame_rd = line;
                    if (sd_oe != !(frame_rd && rise_cnt >= 9)) bad_oe = 1;
                end
                if (!sclk && prev_sclk && frame_rd && rise_cnt >= 9 && rise_cnt < 25
                    && q.size() > 0)
                    radio_drv = q[0].reply[24 - rise_cnt];
            end
            if (!prev_sen && sen_n) begin
                exp_t e;
                if (half_cnt != HALF) bad_t = 1;
                radio_drv = 1'b1;
                idle_cnt = 1;
                frames++;
                if (q.size() == 0) begin
                    chk(0, "R7 unexpected frame", frames, pushed);
                end else begin
                    e = q.pop_front();
                    // R3
                    chk(rise_cnt == (e.rd ? 25 : 24), "R3 pulse count", rise_cnt, e.rd ? 25 : 24);
                    // R1
                    if (e.rd) chk(cap[24:17] == {e.rd, e.addr}, "R1 read header", cap[24:17], {e.rd, e.addr});
                    else begin
                        chk(cap[23:16] == {e.rd, e.addr}, "R1 write header", cap[23:16], {e.rd, e.addr});
                        chk(cap[15:0] == e.wdata, "R1 write data", cap[15:0], e.wdata);
                    end
                    // R2
                    chk(!bad_t, "R2 half period", bad_t, 0);
                    // R4
                    chk(!bad_oe, "R4 line release", bad_oe, 0);
                    // R5
                    chk(rsp_done == 1'b1, "R5 done with enable", rsp_done, 1);
                    chk_low = 1;
                    if (e.rd) begin
                        // R4
                        chk(rsp_rdata == e.reply, "R4 read data", rsp_rdata, e.reply);
                        last_reply = e.reply;
                    end else begin
                        // R8
                        chk(rsp_rdata == last_reply, "R8 rdata kept", rsp_rdata, last_reply);
                    end
                end
            end else if (sen_n) begin
                idle_cnt++;
            end
            // R6
            if (sen_n && (sd_oe !== 1'b1 || sd_o !== 1'b0 || sclk !== 1'b0)) idle_bad++;
            prev_sclk = sclk;
            prev_sen  = sen_n;
        end
    end

    bit finished = 0;

    initial begin
        repeat (5) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9
        chk(sen_n == 1 && sclk == 0 && sd_oe == 1 && sd_o == 0, "R9 reset pins",
            {sen_n, sclk, sd_oe, sd_o}, 4'b1010);
        chk(req_ready == 1 && rsp_done == 0, "R9 reset handshake", {req_ready, rsp_done}, 2'b10);
        chk(rsp_rdata == 16'h0, "R9 reset rdata", rsp_rdata, 0);

        issue(0, 7'h00, 16'h0000, 16'h0);
        issue(0, 7'h7F, 16'hFFFF, 16'h0);
        issue(1, 7'h11, 16'h0000, 16'hBEEF);
        issue(0, 7'h2A, 16'hA5C3, 16'h0);
        issue(1, 7'h7F, 16'hFFFF, 16'h0001);
        issue(1, 7'h00, 16'h1234, 16'h8000);
        issue(0, 7'h55, 16'h8001, 16'h0);
        issue(1, 7'h40, 16'h0000, 16'h6A59);

        while (q.size() != 0 || !sen_n) @(negedge clk);
        repeat (6) @(negedge clk);
        // R7
        chk(frames == pushed, "R7 no request dropped", frames, pushed);
        // R6
        chk(idle_bad == 0, "R6 idle line", idle_bad, 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule